// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single channel of a free-running event timer. A shared main counter, kept outside the block, is fed to the channel every cycle. The channel holds a programmable comparator and signals an interrupt when the counter moves onto the comparator value. It supports one-shot operation and a periodic mode. In periodic mode a hidden period register, loaded by every comparator write, moves the comparator forward after each match.

A 32-bit mode restricts the comparison to the low half of the counter. In that mode, when the channel is one-shot, the first time the low half rolls over after the comparator was programmed also counts as an event. The interrupt can be signalled as a one-cycle pulse (edge) or as a status bit that software clears (level). The channel also stores a route index for the interrupt controller that sits beside it. Software reaches the channel through a small word-wide register window. Reads return data one cycle after the read strobe.

Top module: `event_timer_channel`

## Requirements
- R1: After reset the control word reads 0 except for the capability bits, bit 4 = periodic capable and bit 5 = 64-bit capable (each 1 when the matching parameter is set); bit 2 reads 1 when the channel lacks 64-bit capability. Both comparator halves read all ones, the status bit reads 0 and the interrupt is low.
- R2: Register window, selected by a 2-bit address: 0 = control, 1 = comparator low word, 2 = comparator high word, 3 = status (bit 0). Control bits are: 0 enable, 1 periodic, 2 32-bit mode, 3 level type (1 = level, 0 = edge), 15 message-delivery capable (reads 0). A read strobe returns the selected word on the read data port one cycle later.
- R3: An event occurs when the counter input changes to a value equal to the comparator. The comparison covers the full 64 bits unless 32-bit mode is in effect. A counter that holds its value produces no further event.
- R4: In edge mode each event raises the interrupt for exactly one clock cycle, in the cycle after the counter reached the comparator. The status bit is not set.
- R5: Every comparator write also loads the same half of a hidden period register. In periodic mode with a non-zero period, each match adds the period to the comparator (modulo 2^32 on the low word in 32-bit mode). A comparator write in the same cycle takes precedence over the advance.
- R6: An event raises the interrupt or the status bit only when the channel enable bit and the global enable input are both set.
- R7: In level mode an event sets the status bit, and the interrupt output follows the status bit.
- R8: Writing 1 to status bit 0 clears the bit and drops the level interrupt. Writing 0 has no effect. A new event in the same cycle keeps the bit set.
- R9: 32-bit mode is in effect when control bit 2 is set or when the channel lacks 64-bit capability. In that mode only the low 32 bits of the counter and the comparator are compared.
- R10: In 32-bit one-shot mode, a change of the counter's low word from 0xFFFFFFFF to 0 is an event. This happens once per programmed comparator: any comparator write rearms it.
- R11: Without periodic capability, the periodic control bit reads 0, cannot be set, and the comparator never advances.
- R12: Control bits [ROUTE_W+7:8] hold a read/write route index, which drives the route output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 2*DW | Main counter value |
| glb_en_i | input | 1 | Global enable |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt line |
| status_o | output | 1 | Interrupt status bit |
| route_o | output | ROUTE_W | Route index for the interrupt controller |

## Verification
The bench builds two copies that share one stimulus. The first uses the defaults: 64-bit and periodic capable. It exercises full-width compares against the 32-bit mode, the periodic advance and the rollover event. The second is built with both capabilities off. On this copy the forced 32-bit mode, the periodic bit that cannot be set and the comparator that never advances can be observed through the same reads and counter steps.

// File: rtl/etc_pkg.sv
package etc_pkg;
   localparam logic [1:0] A_CFG    = 2'd0;
   localparam logic [1:0] A_CMP_LO = 2'd1;
   localparam logic [1:0] A_CMP_HI = 2'd2;
   localparam logic [1:0] A_STAT   = 2'd3;

   localparam int B_EN      = 0;
   localparam int B_PER     = 1;
   localparam int B_M32     = 2;
   localparam int B_LVL     = 3;
   localparam int B_CAP_PER = 4;
   localparam int B_CAP64   = 5;
   localparam int B_ROUTE   = 8;
   localparam int B_CAP_MSG = 15;

   typedef struct packed {
      logic en;
      logic per;
      logic m32;
      logic lvl;
   } chan_cfg_t;
endpackage

// File: rtl/etc_regs.sv
module etc_regs
   import etc_pkg::*;
#(
   parameter int DW      = 32,
   parameter int ROUTE_W = 5,
   parameter bit HAS_64  = 1'b1,
   parameter bit HAS_PER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [1:0]         addr_i,
   input  logic [DW-1:0]      wdata_i,
   input  logic               adv_i,
   output chan_cfg_t          cfg_o,
   output logic [ROUTE_W-1:0] route_o,
   output logic [2*DW-1:0]    cmp_o,
   output logic [2*DW-1:0]    per_o,
   output logic               cmp_wr_o,
   output logic [DW-1:0]      cfg_word_o
);
   localparam int CW = 2 * DW;

   logic               cfg_wr, lo_wr, hi_wr;
   logic               en_q, lvl_q;
   logic [ROUTE_W-1:0] route_q;
   logic [CW-1:0]      cmp_q, per_q, adv_val;
   logic               per_bit, m32_bit;

   assign cfg_wr   = wr_en_i && (addr_i == A_CFG);
   assign lo_wr    = wr_en_i && (addr_i == A_CMP_LO);
   assign hi_wr    = wr_en_i && (addr_i == A_CMP_HI);
   assign cmp_wr_o = lo_wr || hi_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         lvl_q   <= 1'b0;
         route_q <= '0;
      end else if (cfg_wr) begin
         en_q    <= wdata_i[B_EN];
         lvl_q   <= wdata_i[B_LVL];
         route_q <= wdata_i[B_ROUTE +: ROUTE_W];
      end
   end

   generate
      if (HAS_PER) begin : g_per
         logic per_q_bit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      per_q_bit <= 1'b0;
            else if (cfg_wr) per_q_bit <= wdata_i[B_PER];
         end
         assign per_bit = per_q_bit;
      end else begin : g_no_per
         assign per_bit = 1'b0;
      end

      if (HAS_64) begin : g_w64
         logic m32_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      m32_q <= 1'b0;
            else if (cfg_wr) m32_q <= wdata_i[B_M32];
         end
         assign m32_bit = m32_q;
      end else begin : g_w32
         assign m32_bit = 1'b1;
      end
   endgenerate

   assign cfg_o.en  = en_q;
   assign cfg_o.per = per_bit;
   assign cfg_o.m32 = m32_bit;
   assign cfg_o.lvl = lvl_q;

   assign adv_val = m32_bit ? {cmp_q[CW-1:DW], cmp_q[DW-1:0] + per_q[DW-1:0]}
                            : cmp_q + per_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '1;
         per_q <= '0;
      end else if (lo_wr) begin
         cmp_q[DW-1:0] <= wdata_i;
         per_q[DW-1:0] <= wdata_i;
      end else if (hi_wr) begin
         cmp_q[CW-1:DW] <= wdata_i;
         per_q[CW-1:DW] <= wdata_i;
      end else if (adv_i) begin
         cmp_q <= adv_val;
      end
   end

   always_comb begin
      cfg_word_o                       = '0;
      cfg_word_o[B_EN]                 = en_q;
      cfg_word_o[B_PER]                = per_bit;
      cfg_word_o[B_M32]                = m32_bit;
      cfg_word_o[B_LVL]                = lvl_q;
      cfg_word_o[B_CAP_PER]            = HAS_PER;
      cfg_word_o[B_CAP64]              = HAS_64;
      cfg_word_o[B_CAP_MSG]            = 1'b0;
      cfg_word_o[B_ROUTE +: ROUTE_W]   = route_q;
   end

   assign route_o = route_q;
   assign cmp_o   = cmp_q;
   assign per_o   = per_q;
endmodule

// File: rtl/etc_match.sv
module etc_match #(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2*DW-1:0] cnt_i,
   input  logic [2*DW-1:0] cmp_i,
   input  logic [2*DW-1:0] per_i,
   input  logic            m32_i,
   input  logic            periodic_i,
   input  logic            cmp_wr_i,
   output logic            evt_o,
   output logic            adv_o,
   output logic            wrap_seen_o
);
   localparam int CW = 2 * DW;

   logic [CW-1:0] prev_q;
   logic          wrap_seen_q;
   logic          moved, equal, match, wrap, per_nz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cnt_i;
   end

   assign moved  = (cnt_i != prev_q);
   assign equal  = m32_i ? (cnt_i[DW-1:0] == cmp_i[DW-1:0]) : (cnt_i == cmp_i);
   assign match  = moved && equal;
   assign per_nz = m32_i ? (|per_i[DW-1:0]) : (|per_i);

   assign wrap = m32_i && !periodic_i && !wrap_seen_q
              && (&prev_q[DW-1:0]) && (cnt_i[DW-1:0] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wrap_seen_q <= 1'b0;
      else if (cmp_wr_i) wrap_seen_q <= 1'b0;
      else if (wrap)     wrap_seen_q <= 1'b1;
   end

   assign evt_o       = match || wrap;
   assign adv_o       = match && periodic_i && per_nz;
   assign wrap_seen_o = wrap_seen_q;
endmodule

// File: rtl/etc_irq.sv
module etc_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic en_i,
   input  logic glb_en_i,
   input  logic lvl_i,
   input  logic clr_i,
   output logic fire_o,
   output logic irq_o,
   output logic status_o
);
   logic status_q, pulse_q;

   assign fire_o = evt_i && en_i && glb_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         pulse_q <= fire_o && !lvl_i;
         if (fire_o && lvl_i) status_q <= 1'b1;
         else if (clr_i)      status_q <= 1'b0;
      end
   end

   assign irq_o    = lvl_i ? status_q : pulse_q;
   assign status_o = status_q;
endmodule

// File: rtl/event_timer_channel.sv
module event_timer_channel
   import etc_pkg::*;
#(
   parameter int DW      = 32,
   parameter int ROUTE_W = 5,
   parameter bit HAS_64  = 1'b1,
   parameter bit HAS_PER = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2*DW-1:0]    cnt_i,
   input  logic               glb_en_i,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [1:0]         addr_i,
   input  logic [DW-1:0]      wdata_i,
   output logic [DW-1:0]      rdata_o,
   output logic               irq_o,
   output logic               status_o,
   output logic [ROUTE_W-1:0] route_o
);
   localparam int CW = 2 * DW;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("event_timer_channel: DW must be 32");
      end
      if (ROUTE_W < 1 || ROUTE_W > 7) begin : g_bad_route
         $error("event_timer_channel: ROUTE_W must lie in 1..7");
      end
   endgenerate

   chan_cfg_t     cfg;
   logic [CW-1:0] cmp, per;
   logic          cmp_wr, adv, evt, wrap_seen, fire, clr;
   logic [DW-1:0] cfg_word, rd_mux, rdata_q;

   etc_regs #(
      .DW(DW), .ROUTE_W(ROUTE_W), .HAS_64(HAS_64), .HAS_PER(HAS_PER)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .adv_i(adv), .cfg_o(cfg), .route_o(route_o),
      .cmp_o(cmp), .per_o(per), .cmp_wr_o(cmp_wr), .cfg_word_o(cfg_word)
   );

   etc_match #(.DW(DW)) u_match (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cmp_i(cmp), .per_i(per),
      .m32_i(cfg.m32), .periodic_i(cfg.per), .cmp_wr_i(cmp_wr),
      .evt_o(evt), .adv_o(adv), .wrap_seen_o(wrap_seen)
   );

   assign clr = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

   etc_irq u_irq (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .en_i(cfg.en),
      .glb_en_i(glb_en_i), .lvl_i(cfg.lvl), .clr_i(clr),
      .fire_o(fire), .irq_o(irq_o), .status_o(status_o)
   );

   always_comb begin
      case (addr_i)
         A_CFG:    rd_mux = cfg_word;
         A_CMP_LO: rd_mux = cmp[DW-1:0];
         A_CMP_HI: rd_mux = cmp[CW-1:DW];
         default:  rd_mux = {{(DW-1){1'b0}}, status_o};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rd_mux;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
   parameter int CW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_o,
   input logic          status_o,
   input logic          glb_en_i,
   input logic          lvl,
   input logic          fire,
   input logic          clr,
   input logic          cmp_wr,
   input logic          wrap_seen,
   input logic          adv,
   input logic [CW-1:0] cmp
);
   // R6: an edge pulse needs the global enable one cycle earlier
   a_r6_edge_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !lvl) |-> $past(glb_en_i));

   // R4: edge mode never sets the status bit
   a_r4_edge_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && !status_o) |=> !status_o);

   // R8: a write of 1 with no new event clears the status
   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !fire) |=> !status_o);

   // R10: a comparator write rearms the rollover event
   a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr |=> !wrap_seen);

   // R5: a periodic match moves the comparator
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !cmp_wr) |=> (cmp != $past(cmp)));
endmodule

bind event_timer_channel etc_checker #(.CW(2*DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .status_o(status_o),
   .glb_en_i(glb_en_i), .lvl(cfg.lvl), .fire(fire), .clr(clr),
   .cmp_wr(cmp_wr), .wrap_seen(wrap_seen), .adv(adv), .cmp(cmp)
);

// File: tb/event_timer_channel_tb.sv
`timescale 1ns/1ps
module event_timer_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] cnt = '0;
   logic        glb_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, rdata_n;
   logic        irq, irq_n, stat, stat_n;
   logic [4:0]  route, route_n;

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic [31:0] rd_m, rd_n;

   always #10 clk = ~clk;

   event_timer_channel u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .glb_en_i(glb_en),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq), .status_o(stat), .route_o(route)
   );

   event_timer_channel #(.HAS_64(1'b0), .HAS_PER(1'b0)) u_dut_n (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .glb_en_i(glb_en),
      .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata_n), .irq_o(irq_n), .status_o(stat_n), .route_o(route_n)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0;
      rd_m = rdata; rd_n = rdata_n;
   endtask

   task automatic drive(input logic [63:0] v);
      @(negedge clk); cnt = v;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 irq", irq, 0);
      chk("R1 status", stat, 0);
      rd(2'd0); chk("R1 cfg", rd_m, 32'h30); chk("R1 cfg no-cap copy", rd_n, 32'h4);
      rd(2'd1); chk("R1 R2 cmp lo", rd_m, 32'hFFFF_FFFF);
      rd(2'd2); chk("R1 R2 cmp hi", rd_m, 32'hFFFF_FFFF);
      rd(2'd3); chk("R1 status read", rd_m, 0);
   endtask

   task automatic t_oneshot;
      glb_en = 1'b1;
      wr(2'd2, 32'h0); wr(2'd1, 32'd50); wr(2'd0, 32'h1);
      drive(64'd49); chk("R3 before match", irq, 0);
      drive(64'd50); chk("R3 match pulse", irq, 1); chk("R4 status stays 0", stat, 0);
      drive(64'd51); chk("R4 pulse one cycle", irq, 0);
   endtask

   task automatic t_gate;
      wr(2'd0, 32'h0); wr(2'd1, 32'd60);
      drive(64'd60); chk("R6 channel disabled", irq, 0);
      wr(2'd0, 32'h1); glb_en = 1'b0; wr(2'd1, 32'd70);
      drive(64'd70); chk("R6 global disabled", irq, 0);
      glb_en = 1'b1;
      drive(64'd71);
   endtask

   task automatic t_level;
      wr(2'd0, 32'h9); wr(2'd1, 32'd80);
      drive(64'd80); chk("R7 level irq", irq, 1); chk("R7 status set", stat, 1);
      drive(64'd81); chk("R7 irq held", irq, 1);
      wr(2'd3, 32'h0); rd(2'd3); chk("R8 write 0 no effect", rd_m, 1);
      wr(2'd3, 32'h1); chk("R8 w1c irq", irq, 0); chk("R8 w1c status", stat, 0);
   endtask

   task automatic t_period;
      wr(2'd0, 32'h3); wr(2'd1, 32'd100);
      rd(2'd0); chk("R11 no-cap periodic bit", rd_n, 32'h5);
      drive(64'd100); chk("R5 first periodic pulse", irq, 1);
      rd(2'd1); chk("R5 advanced once", rd_m, 32'd200); chk("R11 no advance", rd_n, 32'd100);
      drive(64'd150); chk("R5 no pulse between", irq, 0);
      drive(64'd200); chk("R5 second periodic pulse", irq, 1);
      rd(2'd1); chk("R5 advanced twice", rd_m, 32'd300);
   endtask

   task automatic t_m32;
      wr(2'd0, 32'h1); wr(2'd2, 32'h7); wr(2'd1, 32'h5);
      drive(64'h1_0000_0005); chk("R9 64-bit compare misses", irq, 0);
      wr(2'd0, 32'h5);
      drive(64'h1_0000_0004);
      drive(64'h2_0000_0005); chk("R9 32-bit compare hits", irq, 1);
   endtask

   task automatic t_wrap;
      wr(2'd2, 32'h0); wr(2'd1, 32'd10);
      drive(64'h2_FFFF_FFFF); chk("R10 no event before roll", irq, 0);
      drive(64'h3_0000_0000); chk("R10 roll event", irq, 1);
      drive(64'h3_0000_0001); chk("R10 single pulse", irq, 0);
      drive(64'h3_FFFF_FFFF);
      drive(64'h4_0000_0000); chk("R10 second roll silent", irq, 0);
      wr(2'd1, 32'd10);
      drive(64'h4_FFFF_FFFF);
      drive(64'h5_0000_0000); chk("R10 rearmed by write", irq, 1);
   endtask

   task automatic t_route;
      wr(2'd0, 32'h501);
      chk("R12 route out", route, 5'd5);
      rd(2'd0); chk("R12 route readback", rd_m, 32'h531); chk("R12 no-cap readback", rd_n, 32'h505);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_oneshot();
      t_gate();
      t_level();
      t_period();
      t_m32();
      t_wrap();
      t_route();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule